// File: doc/BRIEF.md
# Deferred NCO Frequency Update Controller

This block governs the moment at which a newly programmed oscillator frequency word reaches the NCO. The register bus writes the word into a holding (shadow) register. The active word that the NCO uses changes only after an update event. An update event is either the channel waking from sleep or a hop synchronisation pulse. When an event arrives, a programmable delay starts. The delay is counted in enable pulses from the selected input port. When the delay expires, the held word becomes the active word.

Each update produces a one-cycle commit strobe. A companion bit tells whether a hop or a sleep exit caused the update, so the NCO can clear its phase accumulator only for hops. A busy flag is high while a delayed update is pending. A delay setting of 0 or 1 makes the update take effect on the cycle that follows the event.

Top module: `nco_holdoff_ctrl`

## Requirements
- R1: A bus write (`wr_en` high) loads `wr_data` into the holding register on that clock edge. Such a write never changes `active_word` by itself.
- R2: An update event is `sleep_exit` or `hop_sync` high for one cycle. When both are high in the same cycle, the event counts as a hop.
- R3: An event with `holdoff` of 2 or more loads the counter with `holdoff`-1. `busy` rises in the following cycle, and no commit occurs on that edge.
- R4: While `busy` is high, the counter steps down only in cycles with `port_ce` high. The edge that takes the (`holdoff`-1)-th enable pulse performs the commit, so `commit` is high in the cycle after that pulse.
- R5: An event with `holdoff` equal to 0 or 1 commits on the same edge that samples the event. `commit` is high in the next cycle, and `busy` stays low.
- R6: A commit copies the holding register, as it stands just before the commit edge, into `active_word`. A write on the commit edge itself applies to a later commit.
- R7: `commit` is high for one cycle per commit. `commit_hop` is 1 with it when the last event was a hop and 0 when it was a sleep exit. `commit_hop` is 0 whenever `commit` is 0.
- R8: `busy` is low in the cycle in which `commit` is high.
- R9: An event arriving while `busy` is high restarts the countdown from the current `holdoff`, and its cause replaces the stored one.
- R10: During and directly after reset, `active_word`, `commit`, `commit_hop` and `busy` are 0. The holding register is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe for the frequency word |
| wr_data | input | WORD_W | Frequency word written by the bus |
| holdoff | input | CNT_W | Programmed delay, in input-port enable pulses |
| sleep_exit | input | 1 | One-cycle pulse: channel leaves sleep |
| hop_sync | input | 1 | One-cycle pulse: frequency hop requested |
| port_ce | input | 1 | Enable from the selected input port; steps the delay |
| active_word | output | WORD_W | Frequency word in use by the NCO |
| commit | output | 1 | One-cycle strobe when the active word is updated |
| commit_hop | output | 1 | With commit: 1 when a hop caused the update |
| busy | output | 1 | High while a delayed update is pending |

## Verification
The hardest situation to reach is an event that lands in the middle of a running countdown, combined with a bus write on the same edge that commits. This overlap exercises reload, cause replacement and the ordering between the holding register and the active word together. Random stimulus keeps delays small (0 to 6), makes events frequent relative to those delays, and asserts the enable at about half rate, so these overlaps occur many times. Directed sequences first pin the exact commit cycle for an uninterrupted countdown, a countdown with enable gaps, and a retrigger that changes the cause.

// File: rtl/nco_ho_pkg.sv
package nco_ho_pkg;
  typedef enum logic {
    CAUSE_SLEEP = 1'b0,
    CAUSE_HOP   = 1'b1
  } cause_e;
endpackage

// File: rtl/freq_shadow.sv
module freq_shadow #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] shadow
);
  logic [WORD_W-1:0] shadow_d, shadow_q;

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en) shadow_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  assign shadow = shadow_q;
endmodule

// File: rtl/holdoff_timer.sv
module holdoff_timer
  import nco_ho_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_exit,
  input  logic             hop_sync,
  input  logic             ce,
  input  logic [CNT_W-1:0] holdoff,
  output logic             fire,
  output cause_e           fire_cause,
  output logic             busy
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             busy_d, busy_q;
  cause_e           cause_d, cause_q;
  logic             trig;

  assign trig = sleep_exit | hop_sync;

  always_comb begin
    cnt_d      = cnt_q;
    busy_d     = busy_q;
    cause_d    = cause_q;
    fire       = 1'b0;
    fire_cause = cause_q;
    if (trig) begin
      cause_d = hop_sync ? CAUSE_HOP : CAUSE_SLEEP;
      if (holdoff <= ONE) begin
        fire       = 1'b1;
        fire_cause = cause_d;
        busy_d     = 1'b0;
        cnt_d      = '0;
      end else begin
        cnt_d  = holdoff - ONE;
        busy_d = 1'b1;
      end
    end else if (busy_q && ce) begin
      if (cnt_q == ONE) begin
        fire   = 1'b1;
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      cause_q <= CAUSE_SLEEP;
    end else begin
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      cause_q <= cause_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/freq_commit.sv
module freq_commit
  import nco_ho_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  cause_e            fire_cause,
  input  logic [WORD_W-1:0] shadow,
  output logic [WORD_W-1:0] active,
  output logic              commit,
  output logic              commit_hop
);
  logic [WORD_W-1:0] active_d, active_q;
  logic              commit_d, commit_q;
  logic              hop_d, hop_q;

  always_comb begin
    active_d = active_q;
    commit_d = 1'b0;
    hop_d    = 1'b0;
    if (fire) begin
      active_d = shadow;
      commit_d = 1'b1;
      hop_d    = (fire_cause == CAUSE_HOP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      commit_q <= 1'b0;
      hop_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      commit_q <= commit_d;
      hop_q    <= hop_d;
    end
  end

  assign active     = active_q;
  assign commit     = commit_q;
  assign commit_hop = hop_q;
endmodule

// File: rtl/nco_holdoff_ctrl.sv
module nco_holdoff_ctrl
  import nco_ho_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  holdoff,
  input  logic              sleep_exit,
  input  logic              hop_sync,
  input  logic              port_ce,
  output logic [WORD_W-1:0] active_word,
  output logic              commit,
  output logic              commit_hop,
  output logic              busy
);
  logic [WORD_W-1:0] shadow_q;
  logic              fire;
  cause_e            fire_cause;

  freq_shadow #(.WORD_W(WORD_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .shadow  (shadow_q)
  );

  holdoff_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_exit (sleep_exit),
    .hop_sync   (hop_sync),
    .ce         (port_ce),
    .holdoff    (holdoff),
    .fire       (fire),
    .fire_cause (fire_cause),
    .busy       (busy)
  );

  freq_commit #(.WORD_W(WORD_W)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .fire_cause (fire_cause),
    .shadow     (shadow_q),
    .active     (active_word),
    .commit     (commit),
    .commit_hop (commit_hop)
  );
endmodule

// File: rtl/nco_holdoff_chk.sv
module nco_holdoff_chk #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_exit,
  input logic              hop_sync,
  input logic              port_ce,
  input logic [CNT_W-1:0]  holdoff,
  input logic [WORD_W-1:0] shadow,
  input logic [WORD_W-1:0] active_word,
  input logic              commit,
  input logic              commit_hop,
  input logic              busy
);
  logic trig;
  assign trig = sleep_exit | hop_sync;

  AST_ACTIVE_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_word != $past(active_word)) |-> commit); // R1

  AST_LONG_HOLDOFF_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && holdoff > CNT_W'(1)) |=> (busy && !commit)); // R3

  AST_IDLE_ENABLE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !port_ce && !trig) |=> (busy && !commit)); // R4

  AST_SHORT_HOLDOFF_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && holdoff <= CNT_W'(1)) |=> (commit && !busy)); // R5

  AST_COMMIT_TAKES_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (active_word == $past(shadow))); // R6

  AST_HOP_TAG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    commit_hop |-> commit); // R7

  AST_HOP_WINS_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_sync && holdoff <= CNT_W'(1)) |=> commit_hop); // R2

  AST_NOT_BUSY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy); // R8
endmodule

bind nco_holdoff_ctrl nco_holdoff_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_exit  (sleep_exit),
  .hop_sync    (hop_sync),
  .port_ce     (port_ce),
  .holdoff     (holdoff),
  .shadow      (shadow_q),
  .active_word (active_word),
  .commit      (commit),
  .commit_hop  (commit_hop),
  .busy        (busy)
);

// File: tb/test_nco_holdoff_ctrl.sv
module test_nco_holdoff_ctrl;
  localparam int W = 32;
  localparam int C = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, sleep_exit, hop_sync, port_ce;
  logic [W-1:0] wr_data;
  logic [C-1:0] holdoff;
  logic [W-1:0] active_word;
  logic         commit, commit_hop, busy;

  always #4 clk = ~clk;

  nco_holdoff_ctrl #(.WORD_W(W), .CNT_W(C)) i_nco_holdoff_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .holdoff(holdoff), .sleep_exit(sleep_exit), .hop_sync(hop_sync),
    .port_ce(port_ce), .active_word(active_word), .commit(commit),
    .commit_hop(commit_hop), .busy(busy)
  );

  int vecs = 0;
  int errs = 0;

  // Reference state, derived from the requirements
  logic [W-1:0] m_shadow, m_active;
  logic [C-1:0] m_left;
  logic         m_busy, m_hopcause, m_commit, m_hop;

  function automatic bit short_delay(logic [C-1:0] h);
    return h <= C'(1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_shadow <= '0; m_active <= '0; m_left <= '0;
      m_busy <= 1'b0; m_hopcause <= 1'b0; m_commit <= 1'b0; m_hop <= 1'b0;
    end else begin
      bit go;
      bit cause;
      go = 1'b0;
      cause = m_hopcause;
      m_commit <= 1'b0;
      m_hop    <= 1'b0;
      if (sleep_exit || hop_sync) begin          // R2, R9
        cause = hop_sync;
        m_hopcause <= hop_sync;
        if (short_delay(holdoff)) begin go = 1'b1; m_busy <= 1'b0; end  // R5
        else begin m_left <= holdoff - C'(1); m_busy <= 1'b1; end      // R3
      end else if (m_busy && port_ce) begin      // R4
        if (m_left == C'(1)) begin go = 1'b1; m_busy <= 1'b0; end
        else m_left <= m_left - C'(1);
      end
      if (go) begin
        m_active <= m_shadow;                    // R6
        m_commit <= 1'b1;
        m_hop    <= cause;                       // R7
      end
      if (wr_en) m_shadow <= wr_data;            // R1
    end
  end

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R6", "active_word", active_word, m_active);
    chk("R4", "commit", W'(commit), W'(m_commit));
    chk("R7", "commit_hop", W'(commit_hop), W'(m_hop));
    chk("R8", "busy", W'(busy), W'(m_busy));
  endtask

  task automatic cyc(bit w, logic [W-1:0] d, bit se, bit hs, bit ce);
    @(negedge clk);
    compare_all();
    wr_en = w; wr_data = d; sleep_exit = se; hop_sync = hs; port_ce = ce;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL R10 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 0; wr_data = '0; sleep_exit = 0; hop_sync = 0;
    port_ce = 0; holdoff = '0;
    repeat (3) @(negedge clk);
    chk("R10", "reset active", active_word, '0);
    chk("R10", "reset busy/commit", W'({commit, commit_hop, busy}), '0);
    rst_n = 1'b1;
    idle(2);
    chk("R10", "post-reset active", active_word, '0);

    // R1: write with no event leaves active untouched
    cyc(1'b1, 32'h1234_5678, 0, 0, 1);
    idle(3);
    chk("R1", "write alone", active_word, '0);

    // R5 + R2: zero delay, both events together -> immediate hop commit
    holdoff = C'(0);
    cyc(1'b0, '0, 1, 1, 0);
    idle(1);
    chk("R5", "immediate active", active_word, 32'h1234_5678);
    chk("R2", "tie counts as hop", W'({commit, commit_hop, busy}), W'(3'b110));
    idle(1);
    chk("R7", "strobe one cycle", W'(commit), '0);

    // R3/R4: delay 5 from sleep exit, enable gaps, commit after 4 pulses
    cyc(1'b1, 32'h0000_AAAA, 0, 0, 0);
    holdoff = C'(5);
    cyc(1'b0, '0, 1, 0, 0);
    cyc(1'b0, '0, 0, 0, 1);
    chk("R3", "busy after load", W'({commit, busy}), W'(2'b01));
    cyc(1'b0, '0, 0, 0, 1);
    cyc(1'b0, '0, 0, 0, 0);
    cyc(1'b0, '0, 0, 0, 0);
    cyc(1'b0, '0, 0, 0, 1);
    cyc(1'b1, 32'h0000_BBBB, 0, 0, 1);   // 4th pulse, write on commit edge
    idle(1);
    chk("R4", "commit after 4th pulse", W'({commit, commit_hop, busy}), W'(3'b100));
    chk("R6", "old shadow committed", active_word, 32'h0000_AAAA);

    // R9: hop starts, sleep retrigger reloads with delay 3
    holdoff = C'(4);
    cyc(1'b0, '0, 0, 1, 1);
    cyc(1'b0, '0, 0, 0, 1);
    cyc(1'b0, '0, 0, 0, 1);
    holdoff = C'(3);
    cyc(1'b0, '0, 1, 0, 1);
    cyc(1'b0, '0, 0, 0, 1);
    chk("R9", "still busy after reload", W'({commit, busy}), W'(2'b01));
    cyc(1'b0, '0, 0, 0, 1);
    idle(1);
    chk("R9", "reloaded commit, sleep tag", W'({commit, commit_hop, busy}), W'(3'b100));
    chk("R6", "newer shadow committed", active_word, 32'h0000_BBBB);

    // Random traffic against the reference model
    for (int i = 0; i < 4000; i++) begin
      bit w, se, hs, ce;
      w  = ($urandom_range(0, 3) == 0);
      se = ($urandom_range(0, 9) == 0);
      hs = ($urandom_range(0, 9) == 0);
      ce = $urandom_range(0, 1) != 0;
      if ($urandom_range(0, 15) == 0) holdoff = C'($urandom_range(0, 6));
      cyc(w, $urandom, se, hs, ce);
    end
    idle(10);
    summary();
    $finish;
  end
endmodule